// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block models a single-port synchronous static RAM built from byte lanes. The default is two lanes of 9 bits. On each enabled rising clock edge it registers a command, an address and a pair of active-low lane write enables. Reads and writes use the same two-edge timing, so a read result and the data for a write fall into the same bus slot relative to their commands. The host can therefore issue any mix of reads and writes on consecutive edges, and the shared data bus never needs an idle turnaround cycle.

Commands either load a new address or continue the running burst. A continue ignores the address, the chip selects and the direction input. The low two address bits then step through a four-entry sequence, in either linear or interleaved order. A global stall input freezes the whole block. The output-enable input gates the bus drivers without passing through any register. The bidirectional bus is split into an input port, an output port and a drive-enable port. The array depth is `2**ADDR_W` words, which keeps elaboration small by default.

Top module: `zt_sram`

## Requirements
- R1: An edge with `stall`=0, `load_n`=0, `sel0_n`=0, `sel1`=1, `sel2_n`=0 and `rd_wr`=1 loads a read of `addr`. The stored word is driven on `dq_out` with `dq_oe`=1 during the cycle that ends on the second active edge after the command edge.
- R2: The same selection with `rd_wr`=0 loads a write. `dq_in` is taken at the second active edge after the command. `lane_wen_n[0]`=0 stores bits 8:0 and `lane_wen_n[1]`=0 stores bits 17:9. A lane whose bit is 1 keeps its old value.
- R3: A load edge with any select inactive is a deselect. Nothing is stored and `dq_oe` is 0 in that command's data slot. Continue edges that follow a deselect are also deselects.
- R4: An edge with `load_n`=1 ignores `addr`, the selects and `rd_wr`. It repeats the operation of the burst in progress. The upper address bits stay fixed, and the low two bits return to the start value after four steps.
- R5: The low two bits of the n-th continue after a load at start value s are (s+n) mod 4 when `seq_linear`=1, and s XOR n when `seq_linear`=0.
- R6: A write command or write continue with `lane_wen_n`=2'b11 stores nothing, but the burst address still advances.
- R7: `dq_oe` is 0 whenever `oe_n`=1, and it follows `oe_n` within the same clock cycle. A read issued with `oe_n`=1 still advances the burst.
- R8: An edge with `stall`=1 changes no state. No write takes place, `dq_out` and the drive state hold, and the stalled edge does not count toward any latency.
- R9: `dq_oe` is 0 during the data slot of every write, whatever the state of `oe_n`.
- R10: A read whose address matches a write issued on the previous active edge returns that write's new data in each enabled lane and the old contents in the other lanes.
- R11: After reset `dq_oe` stays 0 until the first read reaches its data slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of pipeline and burst state |
| stall | input | 1 | 1 masks the edge: all state holds |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| load_n | input | 1 | 0 loads a new command, 1 continues the burst |
| rd_wr | input | 1 | On load: 1 read, 0 write |
| lane_wen_n | input | LANES | Per-lane write enables, active low, bit 0 = low lane |
| oe_n | input | 1 | Output enable, active low, combinational |
| seq_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address taken on load edges |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Read data toward the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
Only edges with `stall`=0 count toward latency. A command registered on active edge e has its write data taken at active edge e+2. Its read result is valid from just after active edge e+1 until active edge e+2. The bench keeps its own count of active edges and a two-deep history of the commands it issued. At each active edge it first commits the write from two edges back into its reference array, then derives the expected drive state and data for the command from one edge back. It samples a quarter period after the edge, so the one output register between array and bus has already updated. Stalled cycles expect the previous values unchanged. The `oe_n` toggle checks sample the drive enable one time unit after the change, without any clock edge in between.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    localparam int LANE_W_DEF = 9;
    localparam int LANES_DEF  = 2;
    localparam int BURST_W    = 2;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Position of a burst step: sum (linear) or XOR (interleaved) of start and step.
    function automatic logic [BURST_W-1:0] burst_pos(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input logic               linear
    );
        return linear ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/zt_burst_gen.sv
module zt_burst_gen
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              load,
    input  logic              sel_ok,
    input  logic              rd,
    input  logic              linear,
    input  logic [ADDR_W-1:0] addr_in,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);

    op_e               kind_q;
    logic [ADDR_W-1:0] base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] cnt_nx;

    assign cnt_nx = cnt_q + 1'b1;

    always_comb begin
        if (load) begin
            cmd_op   = sel_ok ? (rd ? OP_READ : OP_WRITE) : OP_IDLE;
            cmd_addr = addr_in;
        end else begin
            cmd_op   = kind_q;
            cmd_addr = {base_q[ADDR_W-1:BURST_W],
                        burst_pos(base_q[BURST_W-1:0], cnt_nx, linear)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= OP_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (advance) begin
            if (load) begin
                kind_q <= cmd_op;
                base_q <= addr_in;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_nx;
            end
        end
    end

    // R4
    burst_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && !load && $past(advance) && !$past(rst)) |-> (cmd_addr != $past(cmd_addr)));

endmodule

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  op_e               in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_wen_n,
    output op_e               rd_op,
    output logic [ADDR_W-1:0] rd_addr,
    output op_e               wr_op,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [LANES-1:0]  wr_wen_n
);

    logic [LANES-1:0] s1_wen_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_op    <= OP_IDLE;
            rd_addr  <= '0;
            s1_wen_n <= '1;
            wr_op    <= OP_IDLE;
            wr_addr  <= '0;
            wr_wen_n <= '1;
        end else if (advance) begin
            rd_op    <= in_op;
            rd_addr  <= in_addr;
            s1_wen_n <= in_wen_n;
            wr_op    <= rd_op;
            wr_addr  <= rd_addr;
            wr_wen_n <= s1_wen_n;
        end
    end

endmodule

// File: rtl/zt_store.sv
module zt_store
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANES  = LANES_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    advance,
    input  op_e                     rd_op,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  op_e                     wr_op,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_wen_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    drive
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] fwd;
    logic              hit;

    assign raw = mem[rd_addr];
    assign hit = (wr_op == OP_WRITE) && (wr_addr == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign fwd[l*LANE_W +: LANE_W] = (hit && !wr_wen_n[l]) ? wdata[l*LANE_W +: LANE_W]
                                                              : raw[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (advance && (wr_op == OP_WRITE)) begin
            for (int l = 0; l < LANES; l++) begin
                if (!wr_wen_n[l]) mem[wr_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            drive <= 1'b0;
        end else if (advance) begin
            drive <= (rd_op == OP_READ);
            if (rd_op == OP_READ) dout <= fwd;
        end
    end

    // R8
    hold_keeps_output_chk: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(dout) && $stable(drive)));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANES  = LANES_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    stall,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    load_n,
    input  logic                    rd_wr,
    input  logic [LANES-1:0]        lane_wen_n,
    input  logic                    oe_n,
    input  logic                    seq_linear,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] dq_in,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);

    localparam int DATA_W = LANES * LANE_W;

    logic              advance;
    logic              sel_ok;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_wen_n;
    logic [DATA_W-1:0] rd_data;
    logic              rd_drive;

    assign advance = !stall;
    assign sel_ok  = !sel0_n && sel1 && !sel2_n;

    zt_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst(rst), .advance(advance), .load(!load_n),
        .sel_ok(sel_ok), .rd(rd_wr), .linear(seq_linear), .addr_in(addr),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr)
    );

    zt_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk(clk), .rst(rst), .advance(advance),
        .in_op(cmd_op), .in_addr(cmd_addr), .in_wen_n(lane_wen_n),
        .rd_op(s1_op), .rd_addr(s1_addr),
        .wr_op(s2_op), .wr_addr(s2_addr), .wr_wen_n(s2_wen_n)
    );

    zt_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
        .clk(clk), .rst(rst), .advance(advance),
        .rd_op(s1_op), .rd_addr(s1_addr),
        .wr_op(s2_op), .wr_addr(s2_addr), .wr_wen_n(s2_wen_n),
        .wdata(dq_in), .dout(rd_data), .drive(rd_drive)
    );

    assign dq_out = rd_data;
    assign dq_oe  = rd_drive && !oe_n;

    // R9
    write_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (s2_op == OP_WRITE) |-> !dq_oe);

    // R3
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (advance && s1_op == OP_IDLE) |=> !dq_oe);

    // R11
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dq_oe);

endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
    import zt_sram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int LW = 9;
    localparam int NL = 2;
    localparam int DW = NL * LW;
    localparam int WIN = 64;
    localparam int WDOG = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stall = 1'b0, sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
    logic load_n = 1'b0, rd_wr = 1'b1, oe_n = 1'b0, seq_linear = 1'b1;
    logic [NL-1:0] lane_wen_n = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe;

    zt_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) u_zt_sram (
        .clk(clk), .rst(rst), .stall(stall), .sel0_n(sel0_n), .sel1(sel1),
        .sel2_n(sel2_n), .load_n(load_n), .rd_wr(rd_wr), .lane_wen_n(lane_wen_n),
        .oe_n(oe_n), .seq_linear(seq_linear), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] a;
        logic [NL-1:0] wen;
        logic [DW-1:0] d;
    } hcmd_t;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [DW-1:0] mdl [WIN];
    hcmd_t h1, h2;
    op_e kb;
    logic [AW-1:0] bb;
    logic [1:0] cb;
    logic exp_drv;
    logic [DW-1:0] exp_dat;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: cycles %0d expected below %0d", cyc, WDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock cycle: drive at negedge, update the reference at posedge, sample a quarter period later.
    task automatic cyc_go(input logic st, input logic ld_n, input logic s0n, input logic s1v,
                          input logic s2n, input logic rw, input logic [AW-1:0] a,
                          input logic [NL-1:0] wn, input logic o_n, input logic lin,
                          input string tag);
        hcmd_t c;
        string slot;
        @(negedge clk);
        stall = st; load_n = ld_n; sel0_n = s0n; sel1 = s1v; sel2_n = s2n;
        rd_wr = rw; addr = a; lane_wen_n = wn; oe_n = o_n; seq_linear = lin;
        dq_in = (!st && h2.op == OP_WRITE) ? h2.d : DW'($urandom);
        @(posedge clk);
        if (st) begin
            slot = "R8";
        end else begin
            if (h2.op == OP_WRITE)
                for (int l = 0; l < NL; l++)
                    if (!h2.wen[l]) mdl[h2.a[5:0]][l*LW +: LW] = h2.d[l*LW +: LW];
            exp_drv = (h1.op == OP_READ);
            if (exp_drv) exp_dat = mdl[h1.a[5:0]];
            if (h1.op == OP_READ)
                slot = (h2.op == OP_WRITE && h2.a == h1.a) ? "R10" : "R1";
            else if (h1.op == OP_WRITE) slot = "R9";
            else slot = "R3";
            c.wen = wn;
            c.d = DW'($urandom);
            if (!ld_n) begin
                if (!s0n && s1v && !s2n) begin
                    c.op = rw ? OP_READ : OP_WRITE;
                    kb = c.op;
                end else begin
                    c.op = OP_IDLE;
                    kb = OP_IDLE;
                end
                c.a = a; bb = a; cb = 2'd0;
            end else begin
                cb = cb + 2'd1;
                c.op = kb;
                c.a = {bb[AW-1:2], lin ? (bb[1:0] + cb) : (bb[1:0] ^ cb)};
            end
            h2 = h1;
            h1 = c;
        end
        if (o_n && exp_drv) slot = "R7";
        #(CLK_PERIOD/4);
        chk({tag, " ", slot, " drive"}, DW'(dq_oe), DW'(exp_drv && !o_n));
        if (exp_drv && !o_n) chk({tag, " ", slot, " data"}, dq_out, exp_dat);
    endtask

    task automatic rd_at(input logic [AW-1:0] a, input string tag);
        cyc_go(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, a, 2'b00, 1'b0, 1'b1, tag);
    endtask

    task automatic wr_at(input logic [AW-1:0] a, input logic [NL-1:0] wn, input string tag);
        cyc_go(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, a, wn, 1'b0, 1'b1, tag);
    endtask

    task automatic cont(input logic lin, input string tag);
        cyc_go(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, AW'($urandom), 2'b00, 1'b0, lin, tag);
    endtask

    task automatic desel(input string tag);
        cyc_go(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, AW'($urandom % WIN), 2'b00, 1'b0, 1'b1, tag);
    endtask

    initial begin
        logic st, ldn, s0, s1v, s2, rw, on, lin;
        logic [NL-1:0] wn;
        int r;
        void'($urandom(32'd20250611));
        h1 = '0; h2 = '0; kb = OP_IDLE; bb = '0; cb = '0;
        exp_drv = 1'b0; exp_dat = '0;
        h1.op = OP_IDLE; h2.op = OP_IDLE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11: bus stays quiet after reset
        repeat (3) desel("R11");

        // Fill the window with linear write bursts (R2, R4)
        for (int b = 0; b < WIN / 4; b++) begin
            wr_at(AW'(b * 4), 2'b00, "R2");
            repeat (3) cont(1'b1, "R4");
        end
        repeat (2) desel("R3");

        // R5 linear order from start 2, then a fifth step to show the wrap (R4)
        rd_at(AW'(6), "R5");
        repeat (4) cont(1'b1, "R5 R4");
        // R5 interleaved order from start 1
        rd_at(AW'(9), "R5");
        repeat (3) cont(1'b0, "R5");
        desel("R3");

        // R2 lane writes
        wr_at(AW'(20), 2'b10, "R2");
        wr_at(AW'(21), 2'b01, "R2");
        desel("R2");
        rd_at(AW'(20), "R2");
        rd_at(AW'(21), "R2");
        desel("R2");

        // R6 write abort, burst still advances
        wr_at(AW'(24), 2'b11, "R6");
        cyc_go(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, AW'(3), 2'b00, 1'b0, 1'b1, "R6");
        desel("R6");
        rd_at(AW'(24), "R6");
        rd_at(AW'(25), "R6");
        desel("R6");

        // R10 back-to-back write then read of the same word, full and partial
        wr_at(AW'(30), 2'b00, "R10");
        rd_at(AW'(30), "R10");
        wr_at(AW'(31), 2'b10, "R10");
        rd_at(AW'(31), "R10");
        desel("R10");
        desel("R10");

        // R3 deselect followed by continues, with read-like inputs
        desel("R3");
        cyc_go(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, AW'(5), 2'b00, 1'b0, 1'b1, "R3");
        cyc_go(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, AW'(5), 2'b00, 1'b0, 1'b1, "R3");
        desel("R3");

        // R7 dummy read and combinational OE
        cyc_go(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, AW'(12), 2'b00, 1'b1, 1'b1, "R7");
        cyc_go(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, AW'(0), 2'b00, 1'b1, 1'b1, "R7");
        cyc_go(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, AW'(0), 2'b00, 1'b0, 1'b1, "R7");
        oe_n = 1'b1;
        #1 chk("R7 oe release", DW'(dq_oe), DW'(0));
        oe_n = 1'b0;
        #1 chk("R7 oe enable", DW'(dq_oe), DW'(1));
        desel("R7");

        // R8 stall holds read output and blocks a pending write
        rd_at(AW'(40), "R8");
        desel("R8");
        repeat (3) cyc_go(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(41), 2'b00, 1'b0, 1'b1, "R8");
        wr_at(AW'(42), 2'b00, "R8");
        repeat (3) cyc_go(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(42), 2'b00, 1'b0, 1'b1, "R8");
        desel("R8");
        desel("R8");
        rd_at(AW'(42), "R8");
        desel("R8");

        // R9 write slot between reads with OE held active
        rd_at(AW'(1), "R9");
        wr_at(AW'(2), 2'b00, "R9");
        rd_at(AW'(3), "R9");
        desel("R9");
        desel("R9");

        // Constrained random mix
        lin = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 0) lin = ~lin;
            st  = ($urandom % 10) == 0;
            ldn = ($urandom % 10) < 4;
            s0 = 1'b0; s1v = 1'b1; s2 = 1'b0;
            if (($urandom % 10) == 0) begin
                r = int'($urandom % 3);
                if (r == 0) s0 = 1'b1;
                else if (r == 1) s1v = 1'b0;
                else s2 = 1'b1;
            end
            rw = 1'($urandom);
            r = int'($urandom % 8);
            wn = (r < 5) ? 2'b00 : (r == 5) ? 2'b01 : (r == 6) ? 2'b10 : 2'b11;
            on = ($urandom % 10) == 0;
            cyc_go(st, ldn, s0, s1v, s2, rw, AW'($urandom % WIN), wn, on, lin, "rand");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule